// File: doc/BRIEF.md
# PWM Compare Channel with Shadowed Threshold

This block is one output channel of an up-counting timer. A counter outside the block supplies its value. The channel compares that value against an active threshold and drives one waveform pin. In PWM mode 1 the pin is active while the counter is below the threshold. PWM mode 2 inverts this. Two static modes hold the pin at a fixed level.

The threshold can be loaded directly or through a shadow copy. When the shadow copy is in use, the new value moves into the comparison only on the timer's update strobe, so a period is never cut short by a mid-period write.

The external trigger pin is synchronised and edge-detected. A delayed event pulse is sent to the counter logic at a fixed latency. When the fast option is set, the same edge also forces the pin to its active level two cycles sooner.

A channel-direction code is kept in the configuration. It is frozen while the channel is enabled and is reported on a status output. Unsupported configurations raise a flag.

Software writes through a small port with three addresses:
- Address 0 is the control word.
- Address 1 is the mode word.
- Address 2 is the threshold.
- Address 3 is unused.

Top module: `ccx_channel`

## Requirements
- R1: After reset the following all read zero: `oc_o`, `trig_evt_o`, `cfg_bad_o`, `route_o` and `cmp_rd_o`. Shadow and active thresholds are 0, the output mode is "forced low", and preload, fast and channel enable are all 0.
- R2: With preload off (mode bit 3 = 0), a write to address 2 loads both the active and the shadow threshold at that clock edge. `cmp_rd_o` returns the active threshold.
- R3: With preload on, a write to address 2 loads only the shadow, and `cmp_rd_o` returns the shadow. On each cycle with `upd_i`=1 the active threshold takes the shadow value held before that edge. A write and an update in the same cycle therefore give active = old shadow and shadow = new data.
- R4: The mode word bits [5:4] select the output mode: 00 forced low, 01 forced high, 10 PWM1 (active while `cnt_i` < active threshold), 11 PWM2 (the inverse of PWM1). `oc_o` is registered: it shows the level for the counter value and the state of the previous cycle. `oc_o` is 0 whenever the channel enable (control bit 0) is 0 or the direction code is not 00.
- R5: With fast enable on (mode bit 2), a PWM mode selected, and the channel enabled as an output, a rising trigger edge first sampled at clock edge n drives `oc_o` high after edge n+2 for one cycle. This happens whatever the comparison result.
- R6: In the forced modes, or with fast enable off, a trigger edge leaves `oc_o` at its counter-versus-threshold level.
- R7: A rising trigger edge first sampled at edge n produces a one-cycle pulse on `trig_evt_o` after edge n+4, independent of the mode bits.
- R8: The direction code (mode bits [1:0]) only accepts a write when channel enable is 0. Otherwise the old code is kept while the other mode fields update. `route_o` shows the code: 00 output, 01 input from pin 1, 10 input from pin 2, 11 input from the internal trigger.
- R9: `cfg_bad_o` is 1 in either of two cases:
  - the channel is enabled in a PWM mode with preload off and one-pulse (control bit 1) off;
  - the direction code is 11 while internal-trigger select (control bit 2) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cnt_i | input | CW | Current counter value |
| upd_i | input | 1 | Update-event strobe |
| trig_i | input | 1 | Asynchronous trigger pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | CW | Register write data |
| oc_o | output | 1 | Waveform output, active high |
| trig_evt_o | output | 1 | Delayed trigger event pulse for the counter |
| route_o | output | 2 | Stored direction / input-routing code |
| cfg_bad_o | output | 1 | Unsupported configuration flag |
| cmp_rd_o | output | CW | Threshold as seen by a register read |

## Verification
The sharpest overlap is a threshold write arriving in the same cycle as the update strobe while preload is on. In that cycle the shadow takes the new data, but the comparison must switch to the value the shadow held before. The bench provokes this directly and then scans the counter across both candidate thresholds, so a wrong hand-over shows up as a misplaced `oc_o` transition.

A second overlap is a fast trigger edge landing in a cycle where the comparison would drive the pin inactive. It is arranged with the counter held above the threshold, and the bench expects exactly one forced active cycle.

Random phases add writes, update strobes and trigger edges on a ramping counter. Each cycle is judged against a reference model built from the requirements.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

  localparam int ADDR_W = 2;
  localparam int CFG_W  = 6;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd2;

  // control word bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_OPM = 1;
  localparam int CTL_ITS = 2;

  // mode word bit positions
  localparam int MD_DIR_LSB = 0;
  localparam int MD_FAST    = 2;
  localparam int MD_PRE     = 3;
  localparam int MD_OM_LSB  = 4;

  localparam logic [1:0] DIR_OUT = 2'b00;
  localparam logic [1:0] DIR_TRC = 2'b11;

  typedef enum logic [1:0] {
    OM_LOW  = 2'b00,
    OM_HIGH = 2'b01,
    OM_PWM1 = 2'b10,
    OM_PWM2 = 2'b11
  } out_mode_e;

  typedef struct packed {
    logic int_trig;
    logic one_pulse;
    logic chan_en;
  } ctrl_t;

  typedef struct packed {
    out_mode_e  omode;
    logic       preload;
    logic       fast;
    logic [1:0] dir;
  } mode_t;

endpackage

// File: rtl/ccx_cfg_regs.sv
module ccx_cfg_regs
  import ccx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  output ctrl_t             ctrl_o,
  output mode_t             mode_o
);

  ctrl_t ctrl_q, ctrl_d;
  mode_t mode_q, mode_d;
  logic  ctrl_we, mode_we;

  always_comb begin
    ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);
    mode_we = wr_en_i && (wr_addr_i == ADDR_MODE);

    ctrl_d           = ctrl_q;
    ctrl_d.chan_en   = wr_data_i[CTL_EN];
    ctrl_d.one_pulse = wr_data_i[CTL_OPM];
    ctrl_d.int_trig  = wr_data_i[CTL_ITS];

    mode_d         = mode_q;
    mode_d.omode   = out_mode_e'(wr_data_i[MD_OM_LSB +: 2]);
    mode_d.preload = wr_data_i[MD_PRE];
    mode_d.fast    = wr_data_i[MD_FAST];
    // direction field is frozen while the channel runs
    if (!ctrl_q.chan_en) begin
      mode_d.dir = wr_data_i[MD_DIR_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (mode_we) mode_q <= mode_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/ccx_compare.sv
module ccx_compare #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          preload_i,
  input  logic          upd_i,
  output logic [DW-1:0] active_o,
  output logic [DW-1:0] rd_o
);

  logic [DW-1:0] shadow_q, shadow_d;
  logic [DW-1:0] active_q, active_d;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    if (wr_i) shadow_d = wr_data_i;
    if (preload_i) begin
      if (upd_i) active_d = shadow_q;
    end else if (wr_i) begin
      active_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign active_o = active_q;
  assign rd_o     = preload_i ? shadow_q : active_q;

endmodule

// File: rtl/ccx_trig_pipe.sv
module ccx_trig_pipe #(
  parameter int SYNC_STAGES = 2,
  parameter int FAST_LAT    = 3,
  parameter int NORM_LAT    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic fast_hit_o,
  output logic evt_o
);

  // the output flop of the channel supplies the last fast stage
  localparam int FAST_PAD = FAST_LAT - SYNC_STAGES - 1;
  localparam int NORM_PAD = NORM_LAT - SYNC_STAGES;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   edge_w;
  logic [NORM_PAD-1:0]    dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      dly_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], trig_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      dly_q[0] <= edge_w;
      for (int i = 1; i < NORM_PAD; i++) begin
        dly_q[i] <= dly_q[i-1];
      end
    end
  end

  assign edge_w = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign evt_o  = dly_q[NORM_PAD-1];

  generate
    if (FAST_PAD == 0) begin : g_fast_direct
      assign fast_hit_o = edge_w;
    end else begin : g_fast_tap
      assign fast_hit_o = dly_q[FAST_PAD-1];
    end
  endgenerate

endmodule

// File: rtl/ccx_channel.sv
module ccx_channel
  import ccx_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cnt_i,
  input  logic              upd_i,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CW-1:0]     wr_data_i,
  output logic              oc_o,
  output logic              trig_evt_o,
  output logic [1:0]        route_o,
  output logic              cfg_bad_o,
  output logic [CW-1:0]     cmp_rd_o
);

  ctrl_t         ctrl;
  mode_t         mode;
  logic [CW-1:0] active_cmp;
  logic          fast_hit;
  logic          chan_en, chan_ok, pwm_sel, fast_en, preload_en;
  logic          below, level, oc_d, oc_q;

  ccx_cfg_regs i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i[CFG_W-1:0]),
    .ctrl_o    (ctrl),
    .mode_o    (mode)
  );

  ccx_compare #(.DW(CW)) i_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_en_i && (wr_addr_i == ADDR_CMP)),
    .wr_data_i (wr_data_i),
    .preload_i (preload_en),
    .upd_i     (upd_i),
    .active_o  (active_cmp),
    .rd_o      (cmp_rd_o)
  );

  ccx_trig_pipe #(.SYNC_STAGES(2), .FAST_LAT(3), .NORM_LAT(5)) i_trg (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .fast_hit_o (fast_hit),
    .evt_o      (trig_evt_o)
  );

  assign chan_en    = ctrl.chan_en;
  assign chan_ok    = chan_en && (mode.dir == DIR_OUT);
  assign pwm_sel    = (mode.omode == OM_PWM1) || (mode.omode == OM_PWM2);
  assign fast_en    = mode.fast;
  assign preload_en = mode.preload;

  always_comb begin
    below = (cnt_i < active_cmp);
    case (mode.omode)
      OM_LOW:  level = 1'b0;
      OM_HIGH: level = 1'b1;
      OM_PWM1: level = below;
      default: level = ~below;
    endcase
    oc_d = chan_ok && ((fast_hit && fast_en && pwm_sel) || level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_d;
  end

  assign oc_o      = oc_q;
  assign route_o   = mode.dir;
  assign cfg_bad_o = (chan_en && pwm_sel && !preload_en && !ctrl.one_pulse) ||
                     ((mode.dir == DIR_TRC) && !ctrl.int_trig);

endmodule

// File: rtl/ccx_channel_chk.sv
module ccx_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_i,
  input logic          wr_en_i,
  input logic [1:0]    wr_addr_i,
  input logic [CW-1:0] wr_data_i,
  input logic          chan_en,
  input logic          chan_ok,
  input logic          pwm_sel,
  input logic          fast_en,
  input logic          preload_en,
  input logic          fast_hit,
  input logic [CW-1:0] active_cmp,
  input logic          oc_o,
  input logic [1:0]    route_o,
  input logic          trig_evt_o
);

  assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en && wr_en_i && wr_addr_i == 2'd2) |=> (active_cmp == $past(wr_data_i)));

  assert_preload_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && !upd_i) |=> $stable(active_cmp));

  assert_off_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_ok |=> !oc_o);

  assert_fast_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_hit && fast_en && pwm_sel && chan_ok) |=> oc_o);

  assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt_o |=> !trig_evt_o);

  assert_dir_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(route_o));

endmodule

bind ccx_channel ccx_channel_chk #(.CW(CW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_i      (upd_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .chan_en    (chan_en),
  .chan_ok    (chan_ok),
  .pwm_sel    (pwm_sel),
  .fast_en    (fast_en),
  .preload_en (preload_en),
  .fast_hit   (fast_hit),
  .active_cmp (active_cmp),
  .oc_o       (oc_o),
  .route_o    (route_o),
  .trig_evt_o (trig_evt_o)
);

// File: tb/test_ccx_channel.sv
`timescale 1ns/1ps
module test_ccx_channel;

  localparam int CW         = 16;
  localparam int CLK_PERIOD = 10;
  localparam int PER        = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic          upd_i = 1'b0;
  logic          trig_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_addr_i = '0;
  logic [CW-1:0] wr_data_i = '0;
  logic          oc_o, trig_evt_o, cfg_bad_o;
  logic [1:0]    route_o;
  logic [CW-1:0] cmp_rd_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ccx_channel #(.CW(CW)) i_ccx_channel (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .upd_i(upd_i), .trig_i(trig_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .oc_o(oc_o), .trig_evt_o(trig_evt_o), .route_o(route_o),
    .cfg_bad_o(cfg_bad_o), .cmp_rd_o(cmp_rd_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit            m_en, m_op, m_its, m_fast, m_pre;
  bit [1:0]      m_dir, m_om;
  bit [CW-1:0]   m_sh, m_act;
  bit            e_oc, e_evt;
  bit [5:0]      th;
  string         oc_tag;

  function automatic bit lvl_f(bit [1:0] om, bit [CW-1:0] c, bit [CW-1:0] a);
    case (om)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return c < a;
      default: return !(c < a);
    endcase
  endfunction

  function automatic bit [CW-1:0] mk_mode(bit [1:0] om, bit pre, bit fast, bit [1:0] dir);
    return CW'({om, pre, fast, dir});
  endfunction

  function automatic bit [CW-1:0] mk_ctrl(bit en, bit op, bit its);
    return CW'({its, op, en});
  endfunction

  function automatic bit exp_bad();
    return (m_en && m_om[1] && !m_pre && !m_op) || (m_dir == 2'b11 && !m_its);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_op = 0; m_its = 0; m_fast = 0; m_pre = 0;
      m_dir = 0; m_om = 0; m_sh = 0; m_act = 0; e_oc = 0; e_evt = 0; th = 0;
      oc_tag = "R4";
    end else begin
      bit fh, chok, pwm;
      bit [CW-1:0] old_sh;
      fh   = th[1] & ~th[2];
      chok = m_en && (m_dir == 2'b00);
      pwm  = m_om[1];
      e_oc = chok && ((pwm && m_fast && fh) || lvl_f(m_om, cnt_i, m_act));
      if (fh && chok && pwm && m_fast) oc_tag = "R5";
      else if (fh)                     oc_tag = "R6";
      else                             oc_tag = "R4";
      e_evt = th[3] & ~th[4];
      th = {th[4:0], trig_i};
      old_sh = m_sh;
      if (m_pre && upd_i) m_act = old_sh;
      if (wr_en_i && wr_addr_i == 2'd2) begin
        m_sh = wr_data_i;
        if (!m_pre) m_act = wr_data_i;
      end
      if (wr_en_i && wr_addr_i == 2'd1) begin
        if (!m_en) m_dir = wr_data_i[1:0];
        m_fast = wr_data_i[2];
        m_pre  = wr_data_i[3];
        m_om   = wr_data_i[5:4];
      end
      if (wr_en_i && wr_addr_i == 2'd0) begin
        m_en = wr_data_i[0]; m_op = wr_data_i[1]; m_its = wr_data_i[2];
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(oc_o == e_oc, oc_tag, "oc_o", oc_o, e_oc);
      chk(trig_evt_o == e_evt, "R7", "trig_evt_o", trig_evt_o, e_evt);
      chk(route_o == m_dir, "R8", "route_o", route_o, m_dir);
      chk(cfg_bad_o == exp_bad(), "R9", "cfg_bad_o", cfg_bad_o, exp_bad());
      if (m_pre) chk(cmp_rd_o == m_sh, "R3", "cmp_rd_o shadow", cmp_rd_o, m_sh);
      else       chk(cmp_rd_o == m_act, "R2", "cmp_rd_o active", cmp_rd_o, m_act);
    end
  end

  // one clock cycle with the given inputs, driven after a falling edge
  task automatic cyc(bit we, bit [1:0] a, bit [CW-1:0] d, bit up, bit tr, bit [CW-1:0] c);
    @(negedge clk);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; upd_i = up; trig_i = tr; cnt_i = c;
  endtask

  task automatic idle(int n, bit [CW-1:0] c);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, trig_i, c);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state observed while reset is held
    chk(oc_o == 0, "R1", "oc_o at reset", oc_o, 0);
    chk(trig_evt_o == 0, "R1", "trig_evt_o at reset", trig_evt_o, 0);
    chk(cfg_bad_o == 0, "R1", "cfg_bad_o at reset", cfg_bad_o, 0);
    chk(route_o == 0, "R1", "route_o at reset", route_o, 0);
    chk(cmp_rd_o == 0, "R1", "cmp_rd_o at reset", cmp_rd_o, 0);
    rst_n = 1'b1;

    // R2: direct load in PWM1, one-pulse set so config is supported
    cyc(1, 2'd1, mk_mode(2'b10, 0, 1, 2'b00), 0, 0, 0);
    cyc(1, 2'd0, mk_ctrl(1, 1, 0), 0, 0, 0);
    cyc(1, 2'd2, 16'd10, 0, 0, 5);
    for (int c = 8; c < 13; c++) cyc(0, 0, 0, 0, 0, CW'(c));
    // R9: one-pulse cleared with preload off -> flagged
    cyc(1, 2'd0, mk_ctrl(1, 0, 0), 0, 0, 0);
    idle(2, 0);
    // R3: preload on, then write and update in the same cycle
    cyc(1, 2'd1, mk_mode(2'b10, 1, 1, 2'b00), 0, 0, 0);
    cyc(1, 2'd2, 16'd20, 0, 0, 15);
    idle(2, 15);
    cyc(1, 2'd2, 16'd30, 1, 0, 15);
    for (int c = 18; c < 33; c++) cyc(0, 0, 0, 0, 0, CW'(c));
    cyc(0, 0, 0, 1, 0, 25);
    for (int c = 18; c < 33; c++) cyc(0, 0, 0, 0, 0, CW'(c));
    // R5: fast edge with counter above threshold, R7 event pulse
    idle(2, 35);
    cyc(0, 0, 0, 0, 1, 35);
    idle(8, 35);
    cyc(0, 0, 0, 0, 0, 35);
    idle(8, 35);
    // R6: forced-low mode with fast set ignores the trigger
    cyc(1, 2'd1, mk_mode(2'b00, 1, 1, 2'b00), 0, 0, 35);
    cyc(0, 0, 0, 0, 1, 35);
    idle(8, 35);
    // R6: PWM2 with fast cleared
    cyc(1, 2'd1, mk_mode(2'b11, 1, 0, 2'b00), 0, 0, 35);
    cyc(0, 0, 0, 0, 0, 5);
    cyc(0, 0, 0, 0, 1, 5);
    idle(8, 5);
    // R8: direction write while enabled is dropped
    cyc(1, 2'd1, mk_mode(2'b10, 1, 0, 2'b01), 0, 0, 5);
    idle(2, 5);
    cyc(1, 2'd0, mk_ctrl(0, 0, 0), 0, 0, 5);
    cyc(1, 2'd1, mk_mode(2'b10, 1, 0, 2'b11), 0, 0, 5);
    idle(2, 5);
    // R9: internal trigger selected clears the flag
    cyc(1, 2'd0, mk_ctrl(0, 0, 1), 0, 0, 5);
    idle(2, 5);
    cyc(1, 2'd0, mk_ctrl(0, 0, 0), 0, 0, 5);
    cyc(1, 2'd1, mk_mode(2'b10, 1, 1, 2'b00), 0, 0, 5);
    cyc(1, 2'd0, mk_ctrl(1, 0, 0), 0, 0, 5);

    // random phase on a ramping counter
    begin
      bit [CW-1:0] c;
      c = 0;
      for (int i = 0; i < 6000; i++) begin
        bit we, up, tr;
        bit [1:0] a;
        bit [CW-1:0] d;
        int r;
        r  = $urandom_range(0, 99);
        we = (r < 12);
        a  = 2'($urandom_range(0, 3));
        case (a)
          2'd0: d = mk_ctrl($urandom_range(0, 3) != 0, 1'($urandom), 1'($urandom));
          2'd1: d = CW'($urandom_range(0, 63));
          default: d = CW'($urandom_range(0, PER + 4));
        endcase
        up = (c == CW'(PER - 1)) || ($urandom_range(0, 49) == 0);
        tr = ($urandom_range(0, 9) == 0) ? ~trig_i : trig_i;
        cyc(we, a, d, up, tr, c);
        c = (c == CW'(PER - 1)) ? '0 : c + 1'b1;
      end
    end
    idle(4, 0);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule